// File: doc/BRIEF.md
# Exception Context Stacking Sequencer

This block saves a processor's register context to memory when an exception is taken and brings it back when the handler returns. On entry it captures an eight-word snapshot of the register file. It aligns the stack pointer down to an 8-byte boundary and moves the pointer below the resulting frame. It then writes the frame one word per cycle through a single-port synchronous write interface. On return it reads the frame at the current stack pointer back one word per cycle and presents each word, tagged with its register slot, on a restore port. Entries nest, so each new frame lands below the previous one.

A programmable lower bound guards the stack region. The bound is checked against the frame base before any write, so an entry that would go past it raises a fault and leaves memory, pointer and nesting depth alone. A return request that arrives while another handler is pending can be marked as a chain. The block then acknowledges it without popping, so the frame stays in place for the next handler. A return with nothing stacked is reported as an error.

Top module: `ctx_stacker`

## Requirements
- R1: After reset the stack pointer equals the STACK_TOP parameter, the depth is 0, no memory access is issued, the busy flag is low and every event pulse is low.
- R2: An accepted entry computes base = (sp with bits 2:0 cleared) - 32. The status word (slot 7) is written with bit 9 replaced by 1 when sp bit 2 was set (padding inserted), else 0. All other bits of every slot are written unchanged.
- R3: An accepted entry issues eight writes in eight consecutive cycles starting the cycle after the request, the address stepping down by 4: slot 7 at base+28 first, then slots 6, 5, ... 0, with slot 0 at base. The snapshot input carries slot k in bits 32k+31:32k, with slots 0..7 being R0, R1, R2, R3, R12, LR, PC, status.
- R4: The entry-done pulse is high for one cycle, in the cycle after the last write. In that cycle the stack pointer equals base and the depth has risen by one.
- R5: If base is below the limit input, or the aligned pointer is below 32, the entry is refused. The fault pulse is high in the cycle after the request, no write is issued, and pointer and depth are unchanged. A base equal to the limit is accepted.
- R6: An accepted return issues eight reads in consecutive cycles from the stack pointer upward in steps of 4, slot 0 first. Each read's data is shown on the restore port one cycle later, with valid high and the slot number.
- R7: The return-done pulse is high in the cycle after slot 7 is restored. The stack pointer is then the old pointer + 32, plus 4 more when bit 9 of the restored status word is set, and the depth has fallen by one.
- R8: A return request with the chain input high at non-zero depth yields a one-cycle chain pulse in the next cycle, with no memory access and no change to pointer or depth.
- R9: A return request at depth 0 yields a one-cycle error pulse in the next cycle, with no memory access and no change to pointer or depth.
- R10: Requests arriving while busy are ignored. When entry and return are requested in the same idle cycle, the entry is taken and the return is dropped. At most one event pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stk_limit_i | input | AW | Lowest address a frame may occupy |
| entry_req_i | input | 1 | Request to stack the snapshot (one-cycle strobe) |
| ret_req_i | input | 1 | Request to unstack one frame (one-cycle strobe) |
| chain_pend_i | input | 1 | Another handler is pending; qualifies a return as a chain |
| ctx_i | input | 256 | Register snapshot, slot k in bits 32k+31:32k |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | AW | Byte address of the access |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read strobe |
| restore_vld_o | output | 1 | Restore word valid |
| restore_idx_o | output | 3 | Slot number of the restore word |
| restore_word_o | output | 32 | Restored register value |
| push_done_o | output | 1 | Entry complete pulse |
| pop_done_o | output | 1 | Return complete pulse |
| chain_o | output | 1 | Chain acknowledged pulse |
| ovf_fault_o | output | 1 | Stack-limit fault pulse |
| ret_err_o | output | 1 | Return at depth zero pulse |
| busy_o | output | 1 | A frame transfer is in progress |
| sp_o | output | AW | Current stack pointer |
| depth_o | output | DW | Current nesting depth |

## Verification
The assertions assume that the limit input holds steady while a frame is being written, and that the memory returns, one cycle after each read, the word last written to that address. They also assume that strobes last a single cycle, or are simply ignored while busy. The bench keeps the limit fixed for the whole of each sweep pass. Its memory model is a plain word array written and read on the same edge as the design expects. Entries are pushed until the limit refuses one, and that many frames are popped before a final return at depth zero. The padding case arises naturally because the reset pointer is 4 modulo 8, and only the outermost frame needs the pad.

// File: rtl/ctx_stk_pkg.sv
package ctx_stk_pkg;
  localparam int unsigned FRAME_WORDS  = 8;
  localparam int unsigned FRAME_BYTES  = FRAME_WORDS * 4;
  localparam int unsigned FRAME_BITS   = FRAME_WORDS * 32;
  localparam int unsigned PAD_FLAG_BIT = 9;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PUSH  = 2'd1,
    SQ_POP   = 2'd2,
    SQ_DRAIN = 2'd3
  } sq_state_e;

  function automatic logic [31:0] align8_down(input logic [31:0] a);
    return {a[31:3], 3'b000};
  endfunction

  function automatic logic [31:0] frame_base_of(input logic [31:0] sp);
    return align8_down(sp) - 32'(FRAME_BYTES);
  endfunction

  // push walks downward from the top slot of the frame
  function automatic logic [31:0] push_addr(input logic [31:0] base, input logic [2:0] step);
    return base + 32'(FRAME_BYTES - 4) - {27'd0, step, 2'b00};
  endfunction

  // pop walks upward from slot 0
  function automatic logic [31:0] pop_addr(input logic [31:0] base, input logic [2:0] step);
    return base + {27'd0, step, 2'b00};
  endfunction

  function automatic logic [31:0] sp_after_pop(input logic [31:0] base, input logic pad);
    return base + 32'(FRAME_BYTES) + (pad ? 32'd4 : 32'd0);
  endfunction
endpackage

// File: rtl/ctx_sp_unit.sv
module ctx_sp_unit
  import ctx_stk_pkg::*;
#(
  parameter int unsigned    AW        = 32,
  parameter logic [AW-1:0]  STACK_TOP = AW'(32'h2000_7FFC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] limit_i,
  input  logic          push_commit_i,
  input  logic          pop_commit_i,
  input  logic          pop_pad_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] base_o,
  output logic          pad_need_o,
  output logic          ovf_o
);
  logic [AW-1:0] sp_q;
  logic [31:0]   sp_w, base_w, pop_w;
  logic          wrap;

  always_comb begin
    sp_w       = 32'(sp_q);
    base_w     = frame_base_of(sp_w);
    pop_w      = sp_after_pop(sp_w, pop_pad_i);
    wrap       = align8_down(sp_w) < 32'(FRAME_BYTES);
    base_o     = base_w[AW-1:0];
    pad_need_o = sp_q[2];
    ovf_o      = wrap || (base_o < limit_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             sp_q <= STACK_TOP;
    else if (push_commit_i) sp_q <= base_w[AW-1:0];
    else if (pop_commit_i)  sp_q <= pop_w[AW-1:0];
  end

  assign sp_o = sp_q;

  AST_PUSH_SP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    push_commit_i |=> (sp_q[2:0] == 3'b000)); // R4

  AST_POP_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pop_commit_i |=> ((sp_q == $past(sp_q) + AW'(FRAME_BYTES)) ||
                      (sp_q == $past(sp_q) + AW'(FRAME_BYTES + 4)))); // R7
endmodule

// File: rtl/ctx_depth_ctr.sv
module ctx_depth_ctr #(
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [DW-1:0] depth_o,
  output logic          zero_o
);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
    else if (dec_i) cnt_q <= cnt_q - 1'b1;
  end

  assign depth_o = cnt_q;
  assign zero_o  = (cnt_q == '0);

  AST_DEPTH_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_i && dec_i)); // R10

  AST_DEPTH_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> !zero_o); // R9
endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
  import ctx_stk_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  entry_req_i,
  input  logic                  ret_req_i,
  input  logic                  chain_pend_i,
  input  logic                  ovf_i,
  input  logic                  pad_need_i,
  input  logic                  depth_zero_i,
  input  logic [AW-1:0]         base_i,
  input  logic [AW-1:0]         sp_i,
  input  logic [FRAME_BITS-1:0] ctx_i,
  input  logic [31:0]           mem_rdata_i,
  output logic                  mem_we_o,
  output logic                  mem_re_o,
  output logic [AW-1:0]         mem_addr_o,
  output logic [31:0]           mem_wdata_o,
  output logic                  restore_vld_o,
  output logic [2:0]            restore_idx_o,
  output logic                  push_commit_o,
  output logic                  pop_commit_o,
  output logic                  pop_pad_o,
  output logic                  push_done_o,
  output logic                  pop_done_o,
  output logic                  chain_o,
  output logic                  fault_o,
  output logic                  err_o,
  output logic                  busy_o
);
  sq_state_e             state_q;
  logic [2:0]            cnt_q, rd_idx_q, slot;
  logic [AW-1:0]         base_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic                  pad_q, rd_pend_q;
  logic                  idle, ret_any, last_step;
  logic                  entry_go, fault_go, err_go, chain_go, pop_go;
  logic [31:0]           a32, raw;
  logic                  push_ev_q, pop_ev_q, chain_q, fault_q, err_q;

  // named events for the assertions
  always_comb begin
    idle      = (state_q == SQ_IDLE);
    ret_any   = idle && !entry_req_i && ret_req_i;
    entry_go  = idle && entry_req_i && !ovf_i;
    fault_go  = idle && entry_req_i && ovf_i;
    err_go    = ret_any && depth_zero_i;
    chain_go  = ret_any && !depth_zero_i && chain_pend_i;
    pop_go    = ret_any && !depth_zero_i && !chain_pend_i;
    last_step = (cnt_q == 3'd7);
  end

  always_comb begin
    slot = ~cnt_q;
    raw  = frame_q[{slot, 5'b00000} +: 32];
    if (slot == 3'd7) raw[PAD_FLAG_BIT] = pad_q;
    if (state_q == SQ_PUSH) a32 = push_addr(32'(base_q), cnt_q);
    else                    a32 = pop_addr(32'(base_q), cnt_q);
    mem_we_o      = (state_q == SQ_PUSH);
    mem_re_o      = (state_q == SQ_POP);
    mem_addr_o    = a32[AW-1:0];
    mem_wdata_o   = raw;
    push_commit_o = (state_q == SQ_PUSH) && last_step;
    pop_commit_o  = (state_q == SQ_DRAIN);
    pop_pad_o     = mem_rdata_i[PAD_FLAG_BIT];
    busy_o        = !idle;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      base_q  <= '0;
      frame_q <= '0;
      pad_q   <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          cnt_q <= '0;
          if (entry_go) begin
            state_q <= SQ_PUSH;
            base_q  <= base_i;
            frame_q <= ctx_i;
            pad_q   <= pad_need_i;
          end else if (pop_go) begin
            state_q <= SQ_POP;
            base_q  <= sp_i;
          end
        end
        SQ_PUSH: begin
          cnt_q <= cnt_q + 3'd1;
          if (last_step) state_q <= SQ_IDLE;
        end
        SQ_POP: begin
          cnt_q <= cnt_q + 3'd1;
          if (last_step) state_q <= SQ_DRAIN;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_idx_q  <= '0;
      push_ev_q <= 1'b0;
      pop_ev_q  <= 1'b0;
      chain_q   <= 1'b0;
      fault_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      rd_pend_q <= (state_q == SQ_POP);
      rd_idx_q  <= cnt_q;
      push_ev_q <= push_commit_o;
      pop_ev_q  <= pop_commit_o;
      chain_q   <= chain_go;
      fault_q   <= fault_go;
      err_q     <= err_go;
    end
  end

  assign restore_vld_o = rd_pend_q;
  assign restore_idx_o = rd_idx_q;
  assign push_done_o   = push_ev_q;
  assign pop_done_o    = pop_ev_q;
  assign chain_o       = chain_q;
  assign fault_o       = fault_q;
  assign err_o         = err_q;

  AST_WR_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - AW'(4))); // R3

  AST_RD_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re_o && $past(mem_re_o)) |-> (mem_addr_o == $past(mem_addr_o) + AW'(4))); // R6

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_done_o, pop_done_o, chain_o, fault_o, err_o})); // R10

  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o)); // R10
endmodule

// File: rtl/ctx_stacker.sv
module ctx_stacker
  import ctx_stk_pkg::*;
#(
  parameter int unsigned   AW        = 32,
  parameter int unsigned   DW        = 4,
  parameter logic [AW-1:0] STACK_TOP = AW'(32'h2000_7FFC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         stk_limit_i,
  input  logic                  entry_req_i,
  input  logic                  ret_req_i,
  input  logic                  chain_pend_i,
  input  logic [FRAME_BITS-1:0] ctx_i,
  output logic                  mem_we_o,
  output logic                  mem_re_o,
  output logic [AW-1:0]         mem_addr_o,
  output logic [31:0]           mem_wdata_o,
  input  logic [31:0]           mem_rdata_i,
  output logic                  restore_vld_o,
  output logic [2:0]            restore_idx_o,
  output logic [31:0]           restore_word_o,
  output logic                  push_done_o,
  output logic                  pop_done_o,
  output logic                  chain_o,
  output logic                  ovf_fault_o,
  output logic                  ret_err_o,
  output logic                  busy_o,
  output logic [AW-1:0]         sp_o,
  output logic [DW-1:0]         depth_o
);
  logic [AW-1:0] base_w;
  logic          pad_need_w, ovf_w, depth_zero_w;
  logic          push_commit_w, pop_commit_w, pop_pad_w;

  ctx_sp_unit #(.AW(AW), .STACK_TOP(STACK_TOP)) u_sp (
    .clk           (clk),
    .rst_n         (rst_n),
    .limit_i       (stk_limit_i),
    .push_commit_i (push_commit_w),
    .pop_commit_i  (pop_commit_w),
    .pop_pad_i     (pop_pad_w),
    .sp_o          (sp_o),
    .base_o        (base_w),
    .pad_need_o    (pad_need_w),
    .ovf_o         (ovf_w)
  );

  ctx_depth_ctr #(.DW(DW)) u_depth (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_i   (push_commit_w),
    .dec_i   (pop_commit_w),
    .depth_o (depth_o),
    .zero_o  (depth_zero_w)
  );

  ctx_seq #(.AW(AW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .entry_req_i   (entry_req_i),
    .ret_req_i     (ret_req_i),
    .chain_pend_i  (chain_pend_i),
    .ovf_i         (ovf_w),
    .pad_need_i    (pad_need_w),
    .depth_zero_i  (depth_zero_w),
    .base_i        (base_w),
    .sp_i          (sp_o),
    .ctx_i         (ctx_i),
    .mem_rdata_i   (mem_rdata_i),
    .mem_we_o      (mem_we_o),
    .mem_re_o      (mem_re_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o),
    .restore_vld_o (restore_vld_o),
    .restore_idx_o (restore_idx_o),
    .push_commit_o (push_commit_w),
    .pop_commit_o  (pop_commit_w),
    .pop_pad_o     (pop_pad_w),
    .push_done_o   (push_done_o),
    .pop_done_o    (pop_done_o),
    .chain_o       (chain_o),
    .fault_o       (ovf_fault_o),
    .err_o         (ret_err_o),
    .busy_o        (busy_o)
  );

  assign restore_word_o = mem_rdata_i;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_addr_o >= stk_limit_i)); // R5

  AST_FAULT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_fault_o |-> ((sp_o == $past(sp_o)) && (depth_o == $past(depth_o)) && !mem_we_o)); // R5

  AST_CHAIN_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    chain_o |-> ((sp_o == $past(sp_o)) && (depth_o == $past(depth_o)) && !mem_re_o)); // R8

  AST_ERR_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ret_err_o |-> ((depth_o == '0) && (sp_o == $past(sp_o)) && !mem_re_o)); // R9

  AST_PUSH_DEPTH_UP: assert property (@(posedge clk) disable iff (!rst_n)
    push_done_o |-> (depth_o == $past(depth_o) + 1'b1)); // R4
endmodule

// File: tb/tb_ctx_stacker.sv
module tb_ctx_stacker;
  localparam int unsigned AW = 10;
  localparam int unsigned DW = 4;
  localparam logic [AW-1:0] TOP = 10'h3FC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] stk_limit_i = '0;
  logic          entry_req_i = 1'b0, ret_req_i = 1'b0, chain_pend_i = 1'b0;
  logic [255:0]  ctx_i = '0;
  logic          mem_we_o, mem_re_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0]   mem_wdata_o;
  logic [31:0]   mem_rdata_i = '0;
  logic          restore_vld_o;
  logic [2:0]    restore_idx_o;
  logic [31:0]   restore_word_o;
  logic          push_done_o, pop_done_o, chain_o, ovf_fault_o, ret_err_o, busy_o;
  logic [AW-1:0] sp_o;
  logic [DW-1:0] depth_o;

  ctx_stacker #(.AW(AW), .DW(DW), .STACK_TOP(TOP)) dut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0]   mem [0:255];
  logic [AW-1:0] wlog_addr [0:15];
  int            wlog_cyc  [0:15];
  logic [AW-1:0] rlog_addr [0:15];
  logic [31:0]   rs_word   [0:7];
  int            rs_cyc    [0:7];
  int            wn, rdn, rsn, push_cyc, pop_cyc;
  bit            s_push, s_pop, s_chain, s_fault, s_err;

  // memory model and event monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we_o) begin
      mem[mem_addr_o[9:2]] <= mem_wdata_o;
      if (wn < 16) begin wlog_addr[wn] <= mem_addr_o; wlog_cyc[wn] <= cyc; end
      wn <= wn + 1;
    end
    if (mem_re_o) begin
      mem_rdata_i <= mem[mem_addr_o[9:2]];
      if (rdn < 16) rlog_addr[rdn] <= mem_addr_o;
      rdn <= rdn + 1;
    end
    if (restore_vld_o) begin
      rs_word[restore_idx_o] <= restore_word_o;
      rs_cyc[restore_idx_o]  <= cyc;
      rsn <= rsn + 1;
    end
    if (push_done_o) begin s_push <= 1'b1; push_cyc <= cyc; end
    if (pop_done_o)  begin s_pop  <= 1'b1; pop_cyc  <= cyc; end
    if (chain_o)     s_chain <= 1'b1;
    if (ovf_fault_o) s_fault <= 1'b1;
    if (ret_err_o)   s_err   <= 1'b1;
  end

  // bench-side model of the stack
  logic [AW-1:0] exp_sp;
  int            exp_depth;
  int            st_seed [0:15];
  bit            st_pad  [0:15];

  function automatic logic [31:0] gen_word(input int seed, input int k);
    logic [31:0] w;
    w = (32'(seed) * 32'h0107_0513) ^ (32'(k) << 24) ^ 32'h5A00_00C3;
    if (seed % 2 == 1) w[9] = 1'b1; else w[9] = 1'b0;
    return w;
  endfunction

  function automatic logic [31:0] stored_word(input int seed, input int k, input bit pad);
    logic [31:0] w;
    w = gen_word(seed, k);
    if (k == 7) w[9] = pad;
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    wn = 0; rdn = 0; rsn = 0;
    s_push = 0; s_pop = 0; s_chain = 0; s_fault = 0; s_err = 0;
  endtask

  task automatic do_reset(input logic [AW-1:0] lim);
    rst_n = 1'b0; entry_req_i = 0; ret_req_i = 0; chain_pend_i = 0;
    stk_limit_i = lim;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_sp = TOP; exp_depth = 0;
  endtask

  task automatic load_ctx(input int seed);
    for (int k = 0; k < 8; k++) ctx_i[k*32 +: 32] = gen_word(seed, k);
  endtask

  task automatic wait_event();
    for (int t = 0; t < 24; t++) begin
      if (s_push || s_pop || s_chain || s_fault || s_err) break;
      @(negedge clk);
    end
  endtask

  // expected outcome of one entry against the model
  task automatic check_push(input int seed);
    logic [AW-1:0] al, base;
    bit pad, refuse;
    al = {exp_sp[AW-1:3], 3'b000};
    base = al - AW'(32);
    pad = exp_sp[2];
    refuse = (al < AW'(32)) || (base < stk_limit_i);
    if (refuse) begin
      chk(s_fault, "R5 fault pulse", 32'(s_fault), 1);
      chk(!s_push, "R5 no done", 32'(s_push), 0);
      chk(wn == 0, "R5 no write", 32'(wn), 0);
      chk(sp_o == exp_sp, "R5 sp kept", 32'(sp_o), 32'(exp_sp));
      chk(int'(depth_o) == exp_depth, "R5 depth kept", 32'(depth_o), 32'(exp_depth));
    end else begin
      chk(s_push && !s_fault, "R4 done pulse", 32'(s_push), 1);
      chk(wn == 8, "R3 write count", 32'(wn), 8);
      for (int k = 0; k < 8; k++) begin
        chk(wlog_addr[k] == base + AW'(28 - 4*k), "R3 write address",
            32'(wlog_addr[k]), 32'(base + AW'(28 - 4*k)));
        chk(wlog_cyc[k] == wlog_cyc[0] + k, "R3 back-to-back", 32'(wlog_cyc[k]), 32'(wlog_cyc[0] + k));
        chk(mem[base[9:2] + 8'(k)] == stored_word(seed, k, pad), (k == 7) ? "R2 status pad bit" : "R3 slot data",
            mem[base[9:2] + 8'(k)], stored_word(seed, k, pad));
      end
      chk(push_cyc == wlog_cyc[7] + 1, "R4 done timing", 32'(push_cyc), 32'(wlog_cyc[7] + 1));
      chk(sp_o == base, "R2 new sp", 32'(sp_o), 32'(base));
      chk(int'(depth_o) == exp_depth + 1, "R4 depth up", 32'(depth_o), 32'(exp_depth + 1));
      st_seed[exp_depth] = seed; st_pad[exp_depth] = pad;
      exp_depth++; exp_sp = base;
    end
  endtask

  task automatic do_entry(input int seed);
    clear_logs(); load_ctx(seed);
    @(negedge clk) entry_req_i = 1'b1;
    @(negedge clk) entry_req_i = 1'b0;
    wait_event();
    check_push(seed);
  endtask

  task automatic check_pop();
    int s; bit p; logic [AW-1:0] nsp;
    s = st_seed[exp_depth-1]; p = st_pad[exp_depth-1];
    nsp = exp_sp + AW'(32) + (p ? AW'(4) : AW'(0));
    chk(s_pop, "R7 done pulse", 32'(s_pop), 1);
    chk(rdn == 8 && rsn == 8, "R6 read count", 32'(rsn), 8);
    for (int k = 0; k < 8; k++) begin
      chk(rlog_addr[k] == exp_sp + AW'(4*k), "R6 read address", 32'(rlog_addr[k]), 32'(exp_sp + AW'(4*k)));
      chk(rs_word[k] == stored_word(s, k, p), "R6 restored word", rs_word[k], stored_word(s, k, p));
      chk(rs_cyc[k] == rs_cyc[0] + k, "R6 restore order", 32'(rs_cyc[k]), 32'(rs_cyc[0] + k));
    end
    chk(pop_cyc == rs_cyc[7] + 1, "R7 done timing", 32'(pop_cyc), 32'(rs_cyc[7] + 1));
    chk(sp_o == nsp, "R7 sp restored", 32'(sp_o), 32'(nsp));
    chk(int'(depth_o) == exp_depth - 1, "R7 depth down", 32'(depth_o), 32'(exp_depth - 1));
    exp_sp = nsp; exp_depth--;
  endtask

  task automatic do_return(input bit chain);
    clear_logs();
    @(negedge clk) begin ret_req_i = 1'b1; chain_pend_i = chain; end
    @(negedge clk) begin ret_req_i = 1'b0; chain_pend_i = 1'b0; end
    wait_event();
    if (exp_depth == 0) begin
      chk(s_err, "R9 error pulse", 32'(s_err), 1);
      chk(rdn == 0 && wn == 0, "R9 no access", 32'(rdn + wn), 0);
      chk(sp_o == exp_sp, "R9 sp kept", 32'(sp_o), 32'(exp_sp));
      chk(depth_o == '0, "R9 depth zero", 32'(depth_o), 0);
    end else if (chain) begin
      chk(s_chain && !s_pop, "R8 chain pulse", 32'(s_chain), 1);
      chk(rdn == 0 && wn == 0, "R8 no access", 32'(rdn + wn), 0);
      chk(sp_o == exp_sp, "R8 sp kept", 32'(sp_o), 32'(exp_sp));
      chk(int'(depth_o) == exp_depth, "R8 depth kept", 32'(depth_o), 32'(exp_depth));
    end else begin
      check_pop();
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hBAD0_0000 | 32'(i);
    clear_logs();
    do_reset('0);
    // R1 reset state
    chk(sp_o == TOP, "R1 reset sp", 32'(sp_o), 32'(TOP));
    chk(depth_o == '0, "R1 reset depth", 32'(depth_o), 0);
    chk(!mem_we_o && !mem_re_o && !busy_o, "R1 idle outputs", 32'({mem_we_o, mem_re_o, busy_o}), 0);
    chk(!(push_done_o || pop_done_o || chain_o || ovf_fault_o || ret_err_o), "R1 no events", 0, 0);

    do_return(1'b0); // R9 return with nothing stacked

    // sweep of limits: 0 fits all, 3B8 equality boundary, 3B9 one frame, 3F9 none
    for (int li = 0; li < 4; li++) begin
      logic [AW-1:0] lim;
      case (li)
        0: lim = 10'h000;
        1: lim = 10'h3B8;
        2: lim = 10'h3B9;
        default: lim = 10'h3F9;
      endcase
      do_reset(lim);
      for (int j = 0; j < 5; j++) do_entry(li * 16 + j + 1);
      while (exp_depth > 0) do_return(1'b0);
      do_return(1'b0);
      chk(sp_o == TOP, "R7 sp back at top", 32'(sp_o), 32'(TOP));
    end

    // R8 tail chain keeps the frame
    do_reset('0);
    do_entry(70);
    do_return(1'b1);
    do_return(1'b0);

    // R10 requests while busy are ignored
    do_reset('0);
    clear_logs(); load_ctx(81);
    @(negedge clk) entry_req_i = 1'b1;
    @(negedge clk) begin entry_req_i = 1'b1; ret_req_i = 1'b1; end
    @(negedge clk);
    @(negedge clk) begin entry_req_i = 1'b0; ret_req_i = 1'b0; end
    wait_event();
    chk(rdn == 0 && !s_err && !s_chain, "R10 return ignored while busy", 32'(rdn), 0);
    check_push(81);
    repeat (3) @(negedge clk);
    chk(wn == 8 && int'(depth_o) == exp_depth, "R10 entry ignored while busy", 32'(wn), 8);

    // R10 entry wins over a simultaneous return
    clear_logs(); load_ctx(92);
    @(negedge clk) begin entry_req_i = 1'b1; ret_req_i = 1'b1; end
    @(negedge clk) begin entry_req_i = 1'b0; ret_req_i = 1'b0; end
    wait_event();
    chk(rdn == 0 && !s_pop, "R10 entry has priority", 32'(rdn), 0);
    check_push(92);
    do_return(1'b0);
    do_return(1'b0);
    do_return(1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule